// File: doc/BRIEF.md
# Power-State Glitch-Free Clock Selector

This block chooses which of three free-standing oscillators feeds the processor clock input. A fast source (nominally 24 MHz) serves the case where main power is present; a medium source (nominally 4 MHz) serves a call in progress on reduced power; a slow source (nominally 32.768 kHz) serves an idle line on reduced power. The choice is made from two level inputs, a main-power-good flag and a hook-switch level. The block drives an enable for each oscillator and a single output clock.

Changes of source happen while the processor keeps running, so the output must never carry a shortened phase. Each source has its own gate cell: a request shifts through a two-flop chain clocked on the falling edge of that source, and the source is ANDed onto the output only from the last flop. A source may start its chain only once the chains of all other sources are empty. This gives break-before-make switching, and only whole high phases reach the output. A 2-bit status reports which source is currently gated through.

Top module: `clk_pwr_sel`

## Requirements
- R1: With `pwr_good` high, the fast source is selected once switching settles: `active_src` reads 0, `osc_en` reads 3'b001 (bit 0 fast, bit 1 medium, bit 2 slow), and `clk_out` has the fast source's period.
- R2: With `pwr_good` low and `off_hook` high, the medium source is selected: `active_src` reads 1, `osc_en` reads 3'b010, and `clk_out` has the medium period.
- R3: With `pwr_good` low and `off_hook` low, the slow source is selected: `active_src` reads 2, `osc_en` reads 3'b100, and `clk_out` has the slow period.
- R4: While `pwr_good` is high, changes of `off_hook` have no effect: `active_src` stays 0 and `osc_en` stays 3'b001.
- R5: At no time are two bits of `osc_en` high together. A source that is still gated onto the output keeps its enable high until its gate has closed.
- R6: At no time are two sources gated onto `clk_out` together. In a settled state, `clk_out` repeats the selected source exactly.
- R7: Every high phase of `clk_out` lasts exactly one half period of one of the sources, and no low phase is shorter than the shortest source half period. This holds during repeated live switching between the medium and slow sources.
- R8: While `rst_n` is low, all gates are closed: `clk_out` stays low and `active_src` reads 3, while the enable of the source the policy picks is already high. After release, the picked source is gated through with no processor reset.
- R9: `active_src` codes the gated source as 0 fast, 1 medium, 2 slow, and 3 when none is gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast oscillator clock |
| clk_med | input | 1 | Medium oscillator clock |
| clk_slow | input | 1 | Slow oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | High when main power is present |
| off_hook | input | 1 | High when a call is in progress |
| osc_en | output | 3 | Oscillator enables: bit 0 fast, bit 1 medium, bit 2 slow |
| clk_out | output | 1 | Selected processor clock |
| active_src | output | 2 | Gated source code (0 fast, 1 medium, 2 slow, 3 none) |

## Verification
On every fast-clock cycle, the bound checker confirms that at most one oscillator enable and at most one gate are active, that an open gate always has its own oscillator enabled, and that reset holds every gate closed. Whether the policy settles on the right source for each input pair, whether the output period matches that source, and whether live switching bursts leave only whole phases can only be shown by the bench scenarios. The bench measures every `clk_out` phase against the known half periods.

// File: rtl/clk_pwr_sel_pkg.sv
package clk_pwr_sel_pkg;
  localparam int NUM_SRC     = 3;
  localparam int SRC_W       = 2;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_FAST = 2'd0,
    SRC_MED  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_NONE = 2'd3
  } src_code_e;
endpackage

// File: rtl/clk_sel_policy.sv
// Maps power and hook levels to a one-hot wish vector (bit 0 fast, 1 medium, 2 slow).
module clk_sel_policy
  import clk_pwr_sel_pkg::*;
(
  input  logic               pwr_good,
  input  logic               off_hook,
  output logic [NUM_SRC-1:0] want
);
  always_comb begin
    want                 = '0;
    want[int'(SRC_FAST)] = pwr_good;
    want[int'(SRC_MED)]  = ~pwr_good & off_hook;
    want[int'(SRC_SLOW)] = ~pwr_good & ~off_hook;
  end
endmodule

// File: rtl/clk_gate_cell.sv
// One source: request chain clocked on the source's falling edge, then an AND gate.
module clk_gate_cell #(
  parameter int STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic want,
  input  logic others_busy,
  output logic busy,
  output logic gate,
  output logic gclk
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              req;

  // next state: a new request enters only when no other chain holds anything
  always_comb begin
    req     = want & ~others_busy;
    chain_d = {chain_q[STAGES-2:0], req};
  end

  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign busy = |chain_q;
  assign gate = chain_q[STAGES-1];
  // gate only moves while clk_src is low, so the product has whole phases
  assign gclk = clk_src & gate;
endmodule

// File: rtl/clk_out_combine.sv
module clk_out_combine
  import clk_pwr_sel_pkg::*;
(
  input  logic [NUM_SRC-1:0] gclk,
  input  logic [NUM_SRC-1:0] gate,
  output logic               clk_out,
  output logic [SRC_W-1:0]   status
);
  assign clk_out = |gclk;

  always_comb begin
    unique case (gate)
      3'b001:  status = SRC_FAST;
      3'b010:  status = SRC_MED;
      3'b100:  status = SRC_SLOW;
      default: status = SRC_NONE;
    endcase
  end
endmodule

// File: rtl/clk_pwr_sel.sv
module clk_pwr_sel
  import clk_pwr_sel_pkg::*;
(
  input  logic               clk_fast,
  input  logic               clk_med,
  input  logic               clk_slow,
  input  logic               rst_n,
  input  logic               pwr_good,
  input  logic               off_hook,
  output logic [NUM_SRC-1:0] osc_en,
  output logic               clk_out,
  output logic [SRC_W-1:0]   active_src
);
  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] want;
  logic [NUM_SRC-1:0] busy_vec;
  logic [NUM_SRC-1:0] gate_vec;
  logic [NUM_SRC-1:0] gclk_vec;
  logic [NUM_SRC-1:0] others_busy;

  assign src_clk = {clk_slow, clk_med, clk_fast};

  clk_sel_policy u_policy (
    .pwr_good (pwr_good),
    .off_hook (off_hook),
    .want     (want)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [NUM_SRC-1:0] SELF = NUM_SRC'(1) << i;

    assign others_busy[i] = |(busy_vec & ~SELF);

    clk_gate_cell #(.STAGES(SYNC_STAGES)) u_cell (
      .clk_src     (src_clk[i]),
      .rst_n       (rst_n),
      .want        (want[i]),
      .others_busy (others_busy[i]),
      .busy        (busy_vec[i]),
      .gate        (gate_vec[i]),
      .gclk        (gclk_vec[i])
    );

    // keep running while anything is in flight; start only once others drained
    assign osc_en[i] = busy_vec[i] | (want[i] & ~others_busy[i]);
  end

  clk_out_combine u_combine (
    .gclk    (gclk_vec),
    .gate    (gate_vec),
    .clk_out (clk_out),
    .status  (active_src)
  );
endmodule

// File: rtl/clk_pwr_sel_chk.sv
module clk_pwr_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] osc_en,
  input logic [2:0] gate_vec
);
  // R5: break-before-make on the oscillator enables
  assert_en_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(osc_en))
    else $error("two oscillator enables high");

  // R5: a gated source keeps its oscillator running
  assert_gate_keeps_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate_vec & ~osc_en) == 0)
    else $error("gate open with its oscillator disabled");

  // R6: never two sources on the output
  assert_gate_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_vec))
    else $error("two gates open");

  // R8: reset keeps every gate closed
  always @(posedge clk) begin
    if (rst_n == 1'b0) begin
      assert_reset_closed_R8: assert (gate_vec == 3'b000)
        else $error("gate open during reset");
    end
  end
endmodule

bind clk_pwr_sel clk_pwr_sel_chk u_chk (
  .clk      (clk_fast),
  .rst_n    (rst_n),
  .osc_en   (osc_en),
  .gate_vec (gate_vec)
);

// File: tb/tb_clk_pwr_sel.sv
`timescale 1ns/1ps
module tb_clk_pwr_sel;
  logic       clk_fast = 1'b0;
  logic       clk_med  = 1'b0;
  logic       clk_slow = 1'b0;
  logic       rst_n;
  logic       pwr_good;
  logic       off_hook;
  logic [2:0] osc_en;
  logic       clk_out;
  logic [1:0] active_src;

  int total = 0;
  int bad   = 0;
  int runt_hi = 0;
  int runt_lo = 0;
  int en_overlap = 0;
  int reset_edges = 0;
  bit finished = 0;
  realtime last_pos = 0.0;
  realtime last_neg = 0.0;
  bit seen_pos = 0;
  bit seen_neg = 0;

  // 200 MHz fast source; others offset so no edges coincide
  always #2.5 clk_fast = ~clk_fast;
  initial begin #1.3; forever #15 clk_med  = ~clk_med;  end
  initial begin #7.1; forever #75 clk_slow = ~clk_slow; end

  clk_pwr_sel dut (
    .clk_fast (clk_fast), .clk_med (clk_med), .clk_slow (clk_slow),
    .rst_n (rst_n), .pwr_good (pwr_good), .off_hook (off_hook),
    .osc_en (osc_en), .clk_out (clk_out), .active_src (active_src)
  );

  function automatic bit near(input realtime a, input realtime b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  function automatic int exp_code(input bit pg, input bit hk);
    if (pg) return 0;
    return hk ? 1 : 2;
  endfunction

  function automatic realtime exp_period(input int code);
    case (code)
      0: return 5.0;
      1: return 30.0;
      default: return 150.0;
    endcase
  endfunction

  // phase shape monitor (R6 R7)
  always @(posedge clk_out) begin
    if (!rst_n) reset_edges++;
    if (seen_neg && ($realtime - last_neg < 2.49)) runt_lo++;
    last_pos = $realtime;
    seen_pos = 1;
  end
  always @(negedge clk_out) begin
    if (seen_pos) begin
      if (!(near($realtime - last_pos, 2.5) || near($realtime - last_pos, 15.0) ||
            near($realtime - last_pos, 75.0))) runt_hi++;
    end
    last_neg = $realtime;
    seen_neg = 1;
  end
  // enable exclusivity sampled away from source edges (R5)
  always @(negedge clk_fast) begin
    #0.2;
    if (rst_n && ($countones(osc_en) > 1)) en_overlap++;
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit pg, input bit hk);
    @(negedge clk_fast);
    #1;
    pwr_good = pg;
    off_hook = hk;
  endtask

  task automatic verify(input bit pg, input bit hk, input string req);
    int e;
    realtime t0;
    realtime p;
    e = exp_code(pg, hk);
    #1500;
    chk({req, " R9 status"}, active_src == 2'(e), int'(active_src), e);
    chk({req, " R5 osc_en"}, osc_en == (3'b001 << e), int'(osc_en), int'(3'b001 << e));
    @(posedge clk_out);
    t0 = $realtime;
    @(posedge clk_out);
    p = $realtime - t0;
    chk({req, " R6 period_ps"}, near(p, exp_period(e)), int'(p * 1000.0),
        int'(exp_period(e) * 1000.0));
  endtask

  task automatic check_shapes(input string tag);
    chk({tag, " R7 runt_high"}, runt_hi == 0, runt_hi, 0);
    chk({tag, " R7 runt_low"},  runt_lo == 0, runt_lo, 0);
    chk({tag, " R6 R5 en_overlap"}, en_overlap == 0, en_overlap, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0;
    pwr_good = 1'b1;
    off_hook = 1'b0;
    #400;
    // R8: reset state
    chk("R8 clk_out low in reset", clk_out == 1'b0, int'(clk_out), 0);
    chk("R8 R9 status none in reset", active_src == 2'd3, int'(active_src), 3);
    chk("R8 policy enable in reset", osc_en == 3'b001, int'(osc_en), 1);
    chk("R8 no output edges in reset", reset_edges == 0, reset_edges, 0);
    @(negedge clk_fast);
    #1;
    rst_n = 1'b1;
    verify(1'b1, 1'b0, "R1 R8 after release");

    // R4: hook ignored under main power
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, ~off_hook);
      #300;
      chk("R4 status under hook toggle", active_src == 2'd0, int'(active_src), 0);
      chk("R4 osc_en under hook toggle", osc_en == 3'b001, int'(osc_en), 1);
    end

    drive(1'b0, 1'b1);
    verify(1'b0, 1'b1, "R2 directed");
    drive(1'b0, 1'b0);
    verify(1'b0, 1'b0, "R3 directed");
    drive(1'b0, 1'b1);
    verify(1'b0, 1'b1, "R2 slow to medium");

    // R7: rapid live switching between the low-power sources
    for (int k = 0; k < 12; k++) begin
      drive(1'b0, ~off_hook);
      repeat (2 + k * 7) @(negedge clk_fast);
    end
    verify(1'b0, off_hook, "R7 after burst");
    check_shapes("directed burst");

    drive(1'b1, 1'b1);
    verify(1'b1, 1'b1, "R1 return to power");

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      bit pg;
      bit hk;
      pg = ($urandom % 4) == 0;
      hk = $urandom % 2;
      if (($urandom % 3) == 0) begin
        for (int b = 0; b < 6; b++) begin
          drive($urandom % 2, $urandom % 2);
          repeat (1 + ($urandom % 60)) @(negedge clk_fast);
        end
      end
      drive(pg, hk);
      verify(pg, hk, pg ? "R1 random" : (hk ? "R2 random" : "R3 random"));
    end
    check_shapes("random end");
    finish_run();
  end
endmodule